// File: doc/BRIEF.md
# Fixed-Latency Delay Line with Parked Payload

This block delays a stream of valid/data pairs by a fixed number of clock cycles, set by the `DELAY` parameter. A pair accepted on one clock edge leaves on the output exactly `DELAY` edges later. It suits wide payloads, where shifting every bit through `DELAY` stages would cost a large amount of flop toggling.

Each payload is written once into one of `DELAY` storage slots and stays there. Only a valid flag and the slot number travel down a short tag pipeline. The slot is chosen by a find-first search for the lowest free slot. When a tag leaves the last pipeline stage, its slot number selects the parked payload through a read mux. The payload goes into the output register and the slot is returned to the free pool.

Each slot is governed by a two-state machine. In state `SLOT_FREE` it holds nothing. In state `SLOT_HELD` it holds a payload in flight. Transition *claim* (`SLOT_FREE`→`SLOT_HELD`) fires when the allocator grants the slot to an incoming pair. Transition *retire* (`SLOT_HELD`→`SLOT_FREE`) fires when the slot's tag leaves the pipeline and no new pair claims it. Transition *recycle* (`SLOT_HELD`→`SLOT_HELD`) fires when the slot is retired and claimed again on the same edge. Reset puts every slot in `SLOT_FREE`.

Top module: `idshift_delay_line`

## Requirements
- R1: While `rst_n` is low, and for the first `DELAY` cycles after it rises, `out_valid` is 0; `out_data` is 0 after reset until the first pair is delivered. A reset discards every pair in flight.
- R2: A pair with `in_valid`=1 sampled on clock edge k gives `out_valid`=1 right after edge k+`DELAY`, for one cycle per pair.
- R3: The `out_data` shown with that `out_valid` equals the `in_data` sampled with the pair on edge k.
- R4: A cycle with `in_valid`=0 produces no output: `out_valid` is 0 right after edge k+`DELAY`.
- R5: `in_valid` may stay 1 on every cycle without limit and no pair is lost. A slot released on an edge can be claimed by a new pair on that same edge.
- R6: The allocator grants the lowest-index slot that is free or being released on that edge. The number of held slots always equals the number of valid tags in the pipeline, so no payload is overwritten while in flight.
- R7: `out_data` keeps its last delivered value while `out_valid` is 0. `in_data` on cycles with `in_valid`=0 never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair present this cycle |
| in_data | input | DATA_WIDTH | Input payload |
| out_valid | output | 1 | Delayed pair present this cycle |
| out_data | output | DATA_WIDTH | Delayed payload, held between pairs |

## Verification
The bench sweeps every 8-bit on/off pattern of `in_valid`, played back to back. This creates every arrangement of holes in the slot pool, including the full-occupancy case where a slot must be recycled on the edge it is released. A design that refused same-edge reuse would drop pairs or return stale payloads there. An off-by-one tag pipeline would shift every output by a cycle, and both faults show as latency or data mismatches against the arithmetic schedule. A reset taken with pairs in flight checks that no old tag comes out afterwards. Garbage driven on `in_data` during idle cycles would show up on a held `out_data` if an idle cycle wrote into the slot array.

// File: rtl/dly_pkg.sv
package dly_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    // Width of a slot index for a pool of the given depth (at least one bit).
    function automatic int id_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/dly_slot_fsm.sv
module dly_slot_fsm
    import dly_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alloc_i,
    input  logic release_i,
    output logic is_free_o
);

    slot_state_e state_q;
    slot_state_e state_d;

    // Next state: claim, retire or recycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (alloc_i) state_d = SLOT_HELD;      // claim
            end
            SLOT_HELD: begin
                if (alloc_i)        state_d = SLOT_HELD; // recycle
                else if (release_i) state_d = SLOT_FREE; // retire
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        is_free_o = (state_q == SLOT_FREE);
    end

    // R6: a grant only lands on a slot that is free or being released.
    p_claim_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (is_free_o || release_i));

    // R5: a claimed slot is held on the next cycle, even when it is also released.
    p_claim_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> !is_free_o);

    // R6: a release with no new claim returns the slot to the pool.
    p_retire_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !alloc_i) |=> is_free_o);

endmodule

// File: rtl/dly_ffs_alloc.sv
module dly_ffs_alloc #(
    parameter int N   = 8,
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   avail_i,
    output logic [N-1:0]   grant_o,
    output logic [IDW-1:0] idx_o,
    output logic           found_o
);

    // Lowest-index available slot: scan from the top so the lowest wins.
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (avail_i[i]) begin
                idx_o   = IDW'(i);
                found_o = 1'b1;
            end
        end
    end

    always_comb begin
        grant_o = found_o ? (N'(1) << idx_o) : '0;
    end

    // R6: at most one slot granted.
    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R6: the granted slot is available and no lower slot is.
    p_grant_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (((grant_o - N'(1)) & avail_i) == '0) && ((grant_o & avail_i) != '0));

    // R6: any availability yields a grant.
    p_grant_found_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|avail_i) |-> found_o);

endmodule

// File: rtl/dly_tag_pipe.sv
module dly_tag_pipe #(
    parameter int DEPTH = 8,
    parameter int IDW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid_i,
    input  logic [IDW-1:0]   push_id_i,
    output logic             tail_valid_o,
    output logic [IDW-1:0]   tail_id_o,
    output logic [DEPTH-1:0] occ_o
);

    logic [DEPTH-1:0] vld_q;
    logic [IDW-1:0]   id_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    id_q[0]  <= '0;
                end else begin
                    vld_q[0] <= push_valid_i;
                    id_q[0]  <= push_id_i;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    id_q[g]  <= '0;
                end else begin
                    vld_q[g] <= vld_q[g-1];
                    id_q[g]  <= id_q[g-1];
                end
            end
        end
    end

    assign tail_valid_o = vld_q[DEPTH-1];
    assign tail_id_o    = id_q[DEPTH-1];
    assign occ_o        = vld_q;

endmodule

// File: rtl/dly_slot_store.sv
module dly_slot_store #(
    parameter int N   = 8,
    parameter int W   = 32,
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           wr_en_i,
    input  logic [IDW-1:0] wr_idx_i,
    input  logic [W-1:0]   wr_data_i,
    input  logic [IDW-1:0] rd_idx_i,
    output logic [W-1:0]   rd_data_o
);

    logic [W-1:0] mem_q [N];

    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
    end

    assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/idshift_delay_line.sv
module idshift_delay_line #(
    parameter int DELAY      = 8,
    parameter int DATA_WIDTH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [DATA_WIDTH-1:0] in_data,
    output logic                  out_valid,
    output logic [DATA_WIDTH-1:0] out_data
);

    localparam int SLOTS = DELAY;
    localparam int IDW   = dly_pkg::id_width(DELAY);
    localparam int CNTW  = $clog2(DELAY + 1);

    logic [SLOTS-1:0]      free_vec;
    logic [SLOTS-1:0]      rel_vec;
    logic [SLOTS-1:0]      avail_vec;
    logic [SLOTS-1:0]      grant_vec;
    logic [SLOTS-1:0]      alloc_vec;
    logic [SLOTS-1:0]      occ_vec;
    logic [IDW-1:0]        grant_idx;
    logic                  grant_found;
    logic                  tail_valid;
    logic [IDW-1:0]        tail_id;
    logic [DATA_WIDTH-1:0] rd_data;
    logic                  out_valid_q;
    logic [DATA_WIDTH-1:0] out_data_q;

    // Slot leaving the pipeline this cycle is offered again at once.
    assign rel_vec   = tail_valid ? (SLOTS'(1) << tail_id) : '0;
    assign avail_vec = free_vec | rel_vec;
    assign alloc_vec = in_valid ? grant_vec : '0;

    dly_ffs_alloc #(.N(SLOTS), .IDW(IDW)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .avail_i (avail_vec),
        .grant_o (grant_vec),
        .idx_o   (grant_idx),
        .found_o (grant_found)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        dly_slot_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_vec[s]),
            .release_i (rel_vec[s]),
            .is_free_o (free_vec[s])
        );
    end

    dly_tag_pipe #(.DEPTH(DELAY), .IDW(IDW)) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid_i (in_valid & grant_found),
        .push_id_i    (grant_idx),
        .tail_valid_o (tail_valid),
        .tail_id_o    (tail_id),
        .occ_o        (occ_vec)
    );

    dly_slot_store #(.N(SLOTS), .W(DATA_WIDTH), .IDW(IDW)) u_store (
        .clk       (clk),
        .wr_en_i   (in_valid & grant_found),
        .wr_idx_i  (grant_idx),
        .wr_data_i (in_data),
        .rd_idx_i  (tail_id),
        .rd_data_o (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            out_valid_q <= tail_valid;
            if (tail_valid) out_data_q <= rd_data;
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;

    // Cycles since reset, saturating at DELAY; used by the quiet-window check.
    logic [CNTW-1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       since_rst_q <= '0;
        else if (since_rst_q < CNTW'(DELAY)) since_rst_q <= since_rst_q + CNTW'(1);
    end

    // R1: no output during the first DELAY cycles after reset.
    p_quiet_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q < CNTW'(DELAY)) |-> !out_valid);

    // R5: a full-rate stream never finds the pool empty.
    p_no_exhaust_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> grant_found);

    // R6: held slots match tags in flight.
    p_held_matches_inflight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~free_vec) == $countones(occ_vec));

endmodule

// File: tb/tb_idshift_delay_line.sv
`timescale 1ns/1ps
module tb_idshift_delay_line;

    localparam int D    = 5;
    localparam int W    = 8;
    localparam int RING = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;

    idshift_delay_line #(.DELAY(D), .DATA_WIDTH(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #4 clk = ~clk;

    int           checks = 0;
    int           failures = 0;
    int           n = 0;
    int           quiet = 0;
    bit           finished = 0;
    bit           exp_v [RING];
    logic [W-1:0] exp_d [RING];
    logic [W-1:0] last_d = '0;
    string        phase = "R1 start";

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s] step=%0d actual=%0h expected=%0h", req, phase, n, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] d);
        int slot;
        @(negedge clk);
        slot = n % RING;
        if (exp_v[slot]) begin
            check(out_valid === 1'b1, "R2", W'(out_valid), W'(1));
            check(out_data === exp_d[slot], "R3", out_data, exp_d[slot]);
            last_d = exp_d[slot];
        end else begin
            check(out_valid === 1'b0, (quiet <= D) ? "R1" : "R4", W'(out_valid), W'(0));
            check(out_data === last_d, "R7", out_data, last_d);
        end
        exp_v[slot] = 1'b0;
        in_valid = v;
        in_data  = v ? d : W'(n * 13 + 8'hA5);
        exp_v[(n + D + 1) % RING] = v;
        exp_d[(n + D + 1) % RING] = d;
        n++;
        quiet++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < RING; i++) exp_v[i] = 1'b0;
        last_d = '0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check(out_valid === 1'b0, "R1", W'(out_valid), W'(0));
        check(out_data === '0, "R1", out_data, '0);
        rst_n = 1'b1;
        quiet = 0;
    endtask

    function automatic logic [W-1:0] payload(input int k);
        return W'(k * 29 + 7);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        phase = "R1 start";
        do_reset();
        for (int i = 0; i < D + 2; i++) step(1'b1, payload(n));

        // Exhaustive sweep of all 8-bit valid patterns (R2 R3 R4 R6 R7).
        phase = "R6 pattern sweep";
        for (int p = 0; p < 256; p++) begin
            for (int b = 0; b < 8; b++) step(p[b], payload(n));
        end

        // Sustained full rate, same-edge slot recycling.
        phase = "R5 full rate";
        for (int i = 0; i < 300; i++) step(1'b1, payload(n));

        // Reset with pairs in flight; nothing stale may emerge.
        phase = "R1 mid-run reset";
        do_reset();
        for (int i = 0; i < D + 1; i++) step(1'b0, payload(n));
        for (int i = 0; i < 40; i++) step(i[0] | i[2], payload(n));

        // Idle with garbage on in_data; held output must not move.
        phase = "R7 idle hold";
        for (int i = 0; i < 3 * D; i++) step(1'b0, payload(n));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule